// File: doc/BRIEF.md
# Shared-Channel HDLC Frame Arbiter

This block decides which of several HDLC transmitters may use a common signalling channel. Each transmitter watches its own bit of a blocked vector and sends only while that bit is clear. When an opening flag arrives, the arbiter latches the source number and blocks every other source. It then passes the received bytes into a receive FIFO. At the closing flag it appends one status byte. Once that frame has ended, the source that just sent is held back for a number of idle flag periods. This gives the other sources a turn.

The frame-end event is raised only by an actual write of the status byte into the FIFO. If the FIFO cannot hold the whole frame plus its status byte, the arbiter stays in the receiving state. Later frames are then accepted as they come, and each frame that finds no room raises an overflow interrupt. Host software recovers in one of two ways. It can issue a message-complete command, which ends the frame internally. Or it can take the clock mode out of its running value, which suspends the arbiter. A receiver-reset command does not release the arbiter from this state. The host read side of the FIFO is modelled only by a pop strobe that frees one byte.

Top module: `shared_chan_arbiter`

## Requirements
- R1: After reset the state output is 0 (free selection), the blocked vector is all zeros, and neither a FIFO write nor an interrupt is signalled.
- R2: An opening flag accepted in free selection moves the state to 1 (expect) after one clock and to 2 (receive) after the next. From then on the blocked vector has every bit set except the one for the latched source.
- R3: In state 2, during an active frame, a data byte with a valid strobe is written to the FIFO one clock later if the FIFO has at least one free byte. Otherwise the byte is dropped.
- R4: A closing flag in an active frame writes a status byte if one byte is free. Bit 7 of the status byte is 1 when data bytes of the frame were dropped, bit 6 is always 1, and bits 5:0 hold the number of bytes accepted. This write is the frame end, and the state becomes 3 (limited) on the same clock.
- R5: If no byte is free at the closing flag, nothing is written and the state stays 2. The receiving source stays unblocked, all other sources stay blocked, and later opening flags are still accepted.
- R6: For each frame, the first byte it cannot store (data or status) raises the interrupt output for exactly one clock. A frame that stores everything raises none.
- R7: A clock-mode input other than 3 forces state 4 (suspended) one clock later from any state, with all sources blocked. Returning the clock mode to 3 moves the state to 0.
- R8: Command byte 0x80 in state 2 moves the state to 3 without writing to the FIFO. Other command values do not change the state.
- R9: Command byte 0x40 (receiver reset) leaves the state unchanged and ends the current frame. Bytes and a closing flag that follow it are not written until the next opening flag.
- R10: In state 3 only the previous source is blocked. Its opening flags are ignored, while an opening flag from another source moves the state to 1. After LIM_IDLE idle-flag ticks with no opening flag, the state returns to 0.
- R11: A pop strobe frees one FIFO byte when the FIFO is not empty, so a later frame fits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_open_i | input | 1 | Opening-flag detect strobe |
| flag_close_i | input | 1 | Closing-flag detect strobe |
| src_id_i | input | SRC_W | Source number of the transmitter sending the opening flag |
| idle_tick_i | input | 1 | One idle flag period elapsed on the channel |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| clk_mode_i | input | 2 | Clock-mode field; 3 means running |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_data_i | input | 8 | Command byte |
| fifo_pop_i | input | 1 | Host has removed one byte from the FIFO |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write data (data or status byte) |
| blocked_o | output | NSRC | Per-source blocked indication, 1 = must not send |
| rfo_irq_o | output | 1 | Receive frame overflow interrupt pulse |
| state_o | output | 3 | Arbiter state: 0 full, 1 expect, 2 receive, 3 limited, 4 suspended |

## Verification
A wrong internal state shows first on the state output and on the blocked vector, one clock after the triggering strobe. A free-space counter that drifts by one shows up at a later frame boundary. There it either drops the status byte that should have been written, which leaves the state stuck at 2, or writes one that should have been dropped. The fault may lie dormant until the FIFO is nearly full, so the bench mixes random pre-fill levels and frame lengths that straddle the exact fit. It also checks the write and interrupt counts after every frame. A frame counter or drop flag that fails to clear shows up in the status byte of the next frame that completes.

// File: rtl/sca_pkg.sv
package sca_pkg;

   typedef enum logic [2:0] {
      ARB_FULL    = 3'd0,
      ARB_EXPECT  = 3'd1,
      ARB_RECV    = 3'd2,
      ARB_LIMITED = 3'd3,
      ARB_SUSPEND = 3'd4
   } arb_state_e;

   localparam logic [1:0] CLK_MODE_RUN = 2'd3;
   localparam logic [7:0] CMD_MSG_DONE = 8'h80;
   localparam logic [7:0] CMD_RX_RESET = 8'h40;

   localparam int ST_CNT_W = 6;

   typedef struct packed {
      logic                dropped;
      logic                marker;
      logic [ST_CNT_W-1:0] count;
   } rx_status_t;

endpackage

// File: rtl/sca_arb_fsm.sv
module sca_arb_fsm
   import sca_pkg::*;
#(
   parameter int NSRC     = 4,
   parameter int LIM_IDLE = 4,
   localparam int SRC_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
   localparam int IDLE_W  = $clog2(LIM_IDLE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             suspend_req,
   input  logic             flag_open,
   input  logic [SRC_W-1:0] src_id,
   input  logic             idle_tick,
   input  logic             frame_end,
   output arb_state_e       state,
   output logic             open_acc,
   output logic [NSRC-1:0]  blocked
);

   arb_state_e         st_q, st_d;
   logic [SRC_W-1:0]   winner_q;
   logic [IDLE_W-1:0]  idle_q;
   logic               idle_done;

   assign state     = st_q;
   assign idle_done = idle_tick && !flag_open && (idle_q == IDLE_W'(LIM_IDLE - 1));

   always_comb begin
      open_acc = 1'b0;
      if (!suspend_req && flag_open) begin
         unique case (st_q)
            ARB_FULL, ARB_RECV: open_acc = 1'b1;
            ARB_LIMITED:        open_acc = (src_id != winner_q);
            default:            open_acc = 1'b0;
         endcase
      end
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ARB_FULL:    if (open_acc) st_d = ARB_EXPECT;
         ARB_EXPECT:  st_d = ARB_RECV;
         ARB_RECV:    if (frame_end) st_d = ARB_LIMITED;
         ARB_LIMITED: begin
            if (open_acc)       st_d = ARB_EXPECT;
            else if (idle_done) st_d = ARB_FULL;
         end
         ARB_SUSPEND: if (!suspend_req) st_d = ARB_FULL;
         default:     st_d = ARB_SUSPEND;
      endcase
      if (suspend_req) st_d = ARB_SUSPEND;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ARB_FULL;
         winner_q <= '0;
         idle_q   <= '0;
      end else begin
         st_q <= st_d;
         if (open_acc && st_q != ARB_RECV) winner_q <= src_id;
         if (st_q != ARB_LIMITED || flag_open) idle_q <= '0;
         else if (idle_tick)                   idle_q <= idle_q + 1'b1;
      end
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_blk
      always_comb begin
         unique case (st_q)
            ARB_FULL:             blocked[g] = 1'b0;
            ARB_EXPECT, ARB_RECV: blocked[g] = (winner_q != SRC_W'(g));
            ARB_LIMITED:          blocked[g] = (winner_q == SRC_W'(g));
            default:              blocked[g] = 1'b1;
         endcase
      end
   end

   assert_suspend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_req |=> (st_q == ARB_SUSPEND));

   assert_expect_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ARB_EXPECT && !suspend_req) |=> (st_q == ARB_RECV));

   assert_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ARB_RECV && frame_end && !suspend_req) |=> (st_q == ARB_LIMITED));

   assert_recv_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ARB_RECV && !frame_end && !suspend_req) |=> (st_q == ARB_RECV));

endmodule

// File: rtl/sca_rx_path.sv
module sca_rx_path
   import sca_pkg::*;
#(
   parameter int DEPTH  = 8,
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_recv,
   input  logic       open_acc,
   input  logic       flag_close,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rx_reset,
   input  logic       frame_abort,
   input  logic       pop,
   output logic       status_wr,
   output logic       fifo_we,
   output logic [7:0] fifo_wdata,
   output logic       irq
);

   logic [OCC_W-1:0]    occ_q;
   logic                frame_act_q;
   logic [ST_CNT_W-1:0] cnt_q;
   logic                dropped_q;
   logic                irq_done_q;
   logic                has_room, data_try, close_try, data_wr, drop;
   rx_status_t          status;

   assign has_room  = (occ_q < OCC_W'(DEPTH));
   assign data_try  = in_recv && frame_act_q && rx_valid && !flag_close;
   assign close_try = in_recv && frame_act_q && flag_close;
   assign data_wr   = data_try && has_room;
   assign status_wr = close_try && has_room;
   assign drop      = (data_try || close_try) && !has_room;

   assign status.dropped = dropped_q;
   assign status.marker  = 1'b1;
   assign status.count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q       <= '0;
         frame_act_q <= 1'b0;
         cnt_q       <= '0;
         dropped_q   <= 1'b0;
         irq_done_q  <= 1'b0;
         fifo_we     <= 1'b0;
         fifo_wdata  <= '0;
         irq         <= 1'b0;
      end else begin
         occ_q <= occ_q + OCC_W'(data_wr || status_wr) - OCC_W'(pop && occ_q != '0);

         if (rx_reset || frame_abort) frame_act_q <= 1'b0;
         else if (open_acc)           frame_act_q <= 1'b1;
         else if (close_try)          frame_act_q <= 1'b0;

         if (open_acc || rx_reset) begin
            cnt_q     <= '0;
            dropped_q <= 1'b0;
         end else begin
            if (data_wr)               cnt_q     <= cnt_q + 1'b1;
            if (data_try && !has_room) dropped_q <= 1'b1;
         end

         if (open_acc)  irq_done_q <= 1'b0;
         else if (drop) irq_done_q <= 1'b1;
         irq <= drop && !irq_done_q;

         fifo_we <= data_wr || status_wr;
         if (status_wr)    fifo_wdata <= status;
         else if (data_wr) fifo_wdata <= rx_data;
      end
   end

   always_comb begin
      if (rst_n) assert_no_overflow_R3: assert (occ_q <= OCC_W'(DEPTH));
   end

   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_no_status_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (close_try && !has_room) |=> !fifo_we);

   assert_pop_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && occ_q != '0 && !data_wr && !status_wr) |=> has_room);

endmodule

// File: rtl/shared_chan_arbiter.sv
module shared_chan_arbiter
   import sca_pkg::*;
#(
   parameter int NSRC       = 4,
   parameter int FIFO_DEPTH = 8,
   parameter int LIM_IDLE   = 4,
   localparam int SRC_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flag_open_i,
   input  logic             flag_close_i,
   input  logic [SRC_W-1:0] src_id_i,
   input  logic             idle_tick_i,
   input  logic             rx_valid_i,
   input  logic [7:0]       rx_data_i,
   input  logic [1:0]       clk_mode_i,
   input  logic             cmd_we_i,
   input  logic [7:0]       cmd_data_i,
   input  logic             fifo_pop_i,
   output logic             fifo_we_o,
   output logic [7:0]       fifo_wdata_o,
   output logic [NSRC-1:0]  blocked_o,
   output logic             rfo_irq_o,
   output logic [2:0]       state_o
);

   if (NSRC < 2) begin : g_bad_nsrc
      $error("shared_chan_arbiter: NSRC must be at least 2");
   end
   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 63) begin : g_bad_depth
      $error("shared_chan_arbiter: FIFO_DEPTH must lie in 2..63");
   end
   if (LIM_IDLE < 1) begin : g_bad_idle
      $error("shared_chan_arbiter: LIM_IDLE must be at least 1");
   end

   arb_state_e st;
   logic       suspend_req, cmd_done, cmd_rxrst, done_in_recv;
   logic       open_acc, status_wr, frame_end;

   assign suspend_req  = (clk_mode_i != CLK_MODE_RUN);
   assign cmd_done     = cmd_we_i && (cmd_data_i == CMD_MSG_DONE);
   assign cmd_rxrst    = cmd_we_i && (cmd_data_i == CMD_RX_RESET);
   assign done_in_recv = cmd_done && (st == ARB_RECV);
   assign frame_end    = status_wr || done_in_recv;
   assign state_o      = st;

   sca_arb_fsm #(
      .NSRC     (NSRC),
      .LIM_IDLE (LIM_IDLE)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .suspend_req (suspend_req),
      .flag_open   (flag_open_i),
      .src_id      (src_id_i),
      .idle_tick   (idle_tick_i),
      .frame_end   (frame_end),
      .state       (st),
      .open_acc    (open_acc),
      .blocked     (blocked_o)
   );

   sca_rx_path #(
      .DEPTH (FIFO_DEPTH)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_recv     (st == ARB_RECV),
      .open_acc    (open_acc),
      .flag_close  (flag_close_i),
      .rx_valid    (rx_valid_i),
      .rx_data     (rx_data_i),
      .rx_reset    (cmd_rxrst),
      .frame_abort (done_in_recv || suspend_req),
      .pop         (fifo_pop_i),
      .status_wr   (status_wr),
      .fifo_we     (fifo_we_o),
      .fifo_wdata  (fifo_wdata_o),
      .irq         (rfo_irq_o)
   );

   assert_cmd_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_in_recv && !suspend_req) |=> (state_o == 3'd3 && !fifo_we_o));

   assert_rxrst_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rxrst && !cmd_done && st == ARB_RECV && !suspend_req && !status_wr) |=> (state_o == 3'd2));

endmodule

// File: tb/tb_shared_chan_arbiter.sv
`timescale 1ns/1ps
module tb_shared_chan_arbiter;

   localparam int NSRC  = 4;
   localparam int DEPTH = 8;
   localparam int LIM   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flag_open_i = 0, flag_close_i = 0, idle_tick_i = 0, rx_valid_i = 0;
   logic [1:0] src_id_i = 0;
   logic [7:0] rx_data_i = 0;
   logic [1:0] clk_mode_i = 2'd3;
   logic       cmd_we_i = 0;
   logic [7:0] cmd_data_i = 0;
   logic       fifo_pop_i = 0;
   logic       fifo_we_o, rfo_irq_o;
   logic [7:0] fifo_wdata_o;
   logic [NSRC-1:0] blocked_o;
   logic [2:0] state_o;

   int n_chk = 0, n_fail = 0;
   int wr_cnt = 0, irq_cnt = 0;
   logic [7:0] last_wr = 0;
   int occ = 0;

   always #2.5 clk = ~clk;

   shared_chan_arbiter #(.NSRC(NSRC), .FIFO_DEPTH(DEPTH), .LIM_IDLE(LIM)) dut (.*);

   always @(negedge clk) begin
      if (fifo_we_o === 1'b1) begin
         wr_cnt++;
         last_wr = fifo_wdata_o;
      end
      if (rfo_irq_o === 1'b1) irq_cnt++;
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not end act=hung exp=done");
      finish_run();
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] all_but(input int s);
      return ~(4'b0001 << s);
   endfunction

   function automatic logic [7:0] stat_byte(input bit dropped, input int cnt);
      return {dropped, 1'b1, 6'(cnt)};
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic open_flag(input int s);
      flag_open_i = 1; src_id_i = 2'(s);
      tick();
      flag_open_i = 0;
   endtask

   task automatic send_bytes(input int n);
      for (int i = 0; i < n; i++) begin
         rx_valid_i = 1; rx_data_i = 8'(8'h30 + i);
         tick();
      end
      rx_valid_i = 0;
   endtask

   task automatic close_flag();
      flag_close_i = 1;
      tick();
      flag_close_i = 0;
   endtask

   task automatic command(input logic [7:0] c);
      cmd_we_i = 1; cmd_data_i = c;
      tick();
      cmd_we_i = 0;
   endtask

   task automatic pops(input int n);
      for (int i = 0; i < n; i++) begin
         fifo_pop_i = 1;
         tick();
      end
      fifo_pop_i = 0;
   endtask

   task automatic force_full();
      clk_mode_i = 2'd0; tick();
      clk_mode_i = 2'd3; tick();
   endtask

   int w0, i0;

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd4242);
      #1;
      chk("R1 state in reset", state_o, 3'd0);
      chk("R1 blocked in reset", blocked_o, 4'b0000);
      chk("R1 no write in reset", fifo_we_o, 1'b0);
      chk("R1 no irq in reset", rfo_irq_o, 1'b0);
      tick(); rst_n = 1; tick();
      chk("R1 state after reset", state_o, 3'd0);

      // R2, R3, R4: normal frame from source 1
      w0 = wr_cnt;
      open_flag(1);
      chk("R2 expect state", state_o, 3'd1);
      chk("R2 blocked others", blocked_o, all_but(1));
      tick();
      chk("R2 receive state", state_o, 3'd2);
      send_bytes(3);
      close_flag();
      chk("R4 limited after status", state_o, 3'd3);
      chk("R10 limited blocks winner", blocked_o, 4'b0010);
      tick();
      chk("R3 writes of frame", wr_cnt - w0, 4);
      chk("R4 status byte", last_wr, stat_byte(0, 3));
      occ = 4;

      // R10: winner rejected, idle return
      open_flag(1);
      chk("R10 winner open ignored", state_o, 3'd3);
      idle_tick_i = 1;
      tick(); tick(); tick();
      chk("R10 still limited before LIM", state_o, 3'd3);
      tick();
      idle_tick_i = 0;
      chk("R10 idle return to full", state_o, 3'd0);
      chk("R10 full unblocked", blocked_o, 4'b0000);

      // R5, R6: exact-fit frame leaves no room for status
      w0 = wr_cnt; i0 = irq_cnt;
      open_flag(2); tick();
      send_bytes(4);
      close_flag();
      chk("R5 stuck in receive", state_o, 3'd2);
      chk("R5 only others blocked", blocked_o, all_but(2));
      tick();
      chk("R5 data written no status", wr_cnt - w0, 4);
      chk("R6 one irq for stuck frame", irq_cnt - i0, 1);
      occ = 8;

      // R5, R6: later frame accepted but dropped
      w0 = wr_cnt; i0 = irq_cnt;
      open_flag(0);
      chk("R5 later frame not rejected", state_o, 3'd2);
      chk("R5 winner still unblocked", blocked_o, all_but(2));
      send_bytes(2);
      close_flag();
      tick();
      chk("R6 irq per later frame", irq_cnt - i0, 1);
      chk("R3 full fifo drops", wr_cnt - w0, 0);
      chk("R5 still receive", state_o, 3'd2);

      // R9, R8
      command(8'h40);
      chk("R9 rx reset keeps receive", state_o, 3'd2);
      command(8'h81);
      chk("R8 other command ignored", state_o, 3'd2);
      w0 = wr_cnt;
      command(8'h80);
      chk("R8 msg done to limited", state_o, 3'd3);
      tick();
      chk("R8 no write on msg done", wr_cnt - w0, 0);

      // R7
      clk_mode_i = 2'd1; tick();
      chk("R7 suspend", state_o, 3'd4);
      chk("R7 suspend blocks all", blocked_o, 4'b1111);
      clk_mode_i = 2'd3; tick();
      chk("R7 resume to full", state_o, 3'd0);

      // R4 drop bit, R11 pop mid-frame
      w0 = wr_cnt; i0 = irq_cnt;
      open_flag(3); tick();
      send_bytes(2);
      pops(1);
      close_flag();
      chk("R4 frame end after pop", state_o, 3'd3);
      tick();
      chk("R11 pop made room for status", wr_cnt - w0, 1);
      chk("R4 drop bit in status", last_wr, stat_byte(1, 0));
      chk("R6 irq once with drops", irq_cnt - i0, 1);
      occ = 8;

      // R9: bytes after receiver reset are ignored
      force_full();
      pops(8); occ = 0;
      w0 = wr_cnt;
      open_flag(0); tick();
      send_bytes(1);
      command(8'h40);
      send_bytes(2);
      close_flag();
      chk("R9 no frame end after rx reset", state_o, 3'd2);
      tick();
      chk("R9 only pre-reset byte written", wr_cnt - w0, 1);
      command(8'h80);
      occ = 1;

      // Random frames around the fit boundary
      for (int it = 0; it < 40; it++) begin
         int p, len, s, fr, wexp;
         bit fits;
         force_full();
         chk("R7 forced full", state_o, 3'd0);
         p = (occ == 0) ? 0 : int'($urandom % (occ + 1));
         pops(p); occ -= p;
         fr   = DEPTH - occ;
         len  = 1 + int'($urandom % (DEPTH + 1));
         s    = int'($urandom % NSRC);
         fits = (len < fr);
         wexp = ((len < fr) ? len : fr) + (fits ? 1 : 0);
         w0 = wr_cnt; i0 = irq_cnt;
         open_flag(s); tick();
         send_bytes(len);
         close_flag();
         chk(fits ? "R4 random end" : "R5 random stuck", state_o, fits ? 3'd3 : 3'd2);
         tick();
         chk("R3 R11 random write count", wr_cnt - w0, wexp);
         chk("R6 random irq count", irq_cnt - i0, fits ? 0 : 1);
         if (fits) chk("R4 random status", last_wr, stat_byte(0, len));
         else begin
            command(8'h80);
            chk("R8 random recover", state_o, 3'd3);
         end
         occ += wexp;
      end

      finish_run();
   end

endmodule